// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block performs the memory side of subroutine call and subroutine return for a small processor core. It receives a one-cycle command together with the current frame pointer, stack pointer, program counter and call target. It then steps through the stack accesses over a 32-bit word memory port that uses a request/acknowledge handshake. When it finishes, it presents the new frame pointer, stack pointer and program counter, and pulses a done flag. The register file and instruction decode sit outside the block.

A call builds a 12-byte frame below the current stack pointer. The highest word of the frame is an unused static-chain slot and is never written. The word below it receives the return address, and the lowest word receives the caller's frame pointer. The return address is the program counter plus the length of the calling instruction: 6 bytes for the absolute-target form and 2 bytes for the register-target form. A return reads the saved frame pointer at the current frame pointer and the return address one word above it. It then leaves the stack pointer 12 bytes above the old frame pointer.

Memory words travel as whole 32-bit values in big-endian order, so bits 31:24 belong to the lowest byte address. Each word starts on a 4-byte boundary.

Top module: `frame_seq`

## Requirements
- R1: During and after reset, `fp_o`, `sp_o`, `pc_o`, `done_o` and `mem_req_o` are all zero.
- R2: A call (command code 2'b01 for the absolute form, 2'b10 for the register form) makes exactly two memory accesses, both writes. The first writes to stack pointer minus 8. No access is ever made to stack pointer minus 4, the static-chain slot.
- R3: The second access of a call writes the caller's frame pointer (`fp_i`) to stack pointer minus 12.
- R4: After a call, `fp_o` and `sp_o` both equal the input stack pointer minus 12, and `pc_o` equals `target_i`.
- R5: The word that a call writes first is `pc_i` + 6 for command code 2'b01 and `pc_i` + 2 for command code 2'b10.
- R6: A return (command code 2'b11) makes exactly two memory accesses, both reads. The first reads the address in `fp_i` and the second reads `fp_i` + 4.
- R7: After a return, `fp_o` equals the word read from `fp_i`, `pc_o` equals the word read from `fp_i` + 4, and `sp_o` equals `fp_i` + 12.
- R8: At most one access is outstanding at a time. While `mem_req_o` is high and `mem_ack_i` is low, the address, write enable and write data of the request stay stable.
- R9: A command (any code other than 2'b00) is accepted only when the block is idle. A command presented while a sequence is running has no effect on the accesses or on the results. `mem_req_o` is low in the cycle in which `done_o` is high.
- R10: `done_o` is high for exactly one cycle per command. `fp_o`, `sp_o` and `pc_o` change only in that cycle and hold their values until the next completion.
- R11: Every memory address has its two low bits forced to zero, so an unaligned stack pointer still yields word-aligned accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | 00 none, 01 call absolute, 10 call register, 11 return |
| pc_i | input | XLEN | Address of the calling instruction |
| target_i | input | XLEN | Call destination |
| fp_i | input | XLEN | Current frame pointer |
| sp_i | input | XLEN | Current stack pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | XLEN | Word-aligned byte address |
| mem_wdata_o | output | XLEN | Write data |
| mem_rdata_i | input | XLEN | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Acknowledge of the current request |
| fp_o | output | XLEN | Resulting frame pointer |
| sp_o | output | XLEN | Resulting stack pointer |
| pc_o | output | XLEN | Resulting program counter |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches the handshake on every cycle. It checks that a pending request holds its address, direction and data until acknowledged, that addresses stay word-aligned, that done is a single-cycle pulse with no request beside it, and that the result registers move only when done is high.

Only the bench scenarios can show the frame contents and results. These are the exact addresses and data of each push, the order of the two reads, the length that each call form adds to the return address, and the values left in the pointers. The bench sweeps stack and frame pointers across acknowledge latencies of zero to three cycles, and it injects a command in the middle of a sequence to confirm that the command is ignored.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE     = 2'b00,
    CMD_CALL_ABS = 2'b01,
    CMD_CALL_REG = 2'b10,
    CMD_RET      = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_RA,
    ST_PUSH_FP,
    ST_POP_FP,
    ST_POP_RA
  } state_e;

  localparam int unsigned WORD_BYTES   = 4;
  localparam int unsigned FRAME_WORDS  = 3;
  localparam int unsigned ABS_CALL_LEN = 6;
  localparam int unsigned REG_CALL_LEN = 2;
endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  cmd_e   cmd_i,
  input  logic   ack_i,
  output state_e state_o,
  output logic   take_o,
  output logic   step_o,
  output logic   finish_o
);
  state_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    take_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_i != CMD_NONE) begin
        take_o = 1'b1;
        st_d   = (cmd_i == CMD_RET) ? ST_POP_FP : ST_PUSH_RA;
      end
      ST_PUSH_RA: if (ack_i) st_d = ST_PUSH_FP;
      ST_PUSH_FP: if (ack_i) st_d = ST_IDLE;
      ST_POP_FP:  if (ack_i) st_d = ST_POP_RA;
      ST_POP_RA:  if (ack_i) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  assign step_o   = (st_q != ST_IDLE) && ack_i;
  assign finish_o = ack_i && (st_q == ST_PUSH_FP || st_q == ST_POP_RA);
  assign state_o  = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/frame_seq_path.sv
module frame_seq_path
  import frame_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  state_e          state_i,
  input  cmd_e            cmd_i,
  input  logic            take_i,
  input  logic            step_i,
  input  logic            finish_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] fp_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic            req_o,
  output logic            we_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] wdata_o,
  output logic [XLEN-1:0] fp_o,
  output logic [XLEN-1:0] sp_o,
  output logic [XLEN-1:0] pc_o,
  output logic            done_o
);
  localparam logic [XLEN-1:0] SLOT  = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] FRAME = XLEN'(WORD_BYTES * FRAME_WORDS);
  localparam logic [XLEN-1:0] AMASK = ~XLEN'(WORD_BYTES - 1);
  localparam logic [XLEN-1:0] LEN_A = XLEN'(ABS_CALL_LEN);
  localparam logic [XLEN-1:0] LEN_R = XLEN'(REG_CALL_LEN);

  logic [XLEN-1:0] base_q, ret_q, ofp_q, tgt_q, ldfp_q;
  logic [XLEN-1:0] raw_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ret_q  <= '0;
      ofp_q  <= '0;
      tgt_q  <= '0;
      ldfp_q <= '0;
    end else begin
      if (take_i) begin
        base_q <= (cmd_i == CMD_RET) ? fp_i : sp_i;
        ret_q  <= pc_i + ((cmd_i == CMD_CALL_ABS) ? LEN_A : LEN_R);
        ofp_q  <= fp_i;
        tgt_q  <= target_i;
      end
      if (step_i && state_i == ST_POP_FP) ldfp_q <= rdata_i;
    end
  end

  // word offsets inside the frame; top slot (static chain) is skipped
  always_comb begin
    unique case (state_i)
      ST_PUSH_RA: raw_addr = base_q - (SLOT << 1);
      ST_PUSH_FP: raw_addr = base_q - FRAME;
      ST_POP_RA:  raw_addr = base_q + SLOT;
      default:    raw_addr = base_q;
    endcase
  end

  assign req_o   = (state_i != ST_IDLE);
  assign we_o    = (state_i == ST_PUSH_RA) || (state_i == ST_PUSH_FP);
  assign addr_o  = raw_addr & AMASK;
  assign wdata_o = (state_i == ST_PUSH_RA) ? ret_q : ofp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_o   <= '0;
      sp_o   <= '0;
      pc_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) begin
        if (state_i == ST_PUSH_FP) begin
          fp_o <= base_q - FRAME;
          sp_o <= base_q - FRAME;
          pc_o <= tgt_q;
        end else begin
          fp_o <= ldfp_q;
          sp_o <= base_q + FRAME;
          pc_o <= rdata_i;
        end
      end
    end
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      cmd_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] fp_i,
  input  logic [XLEN-1:0] sp_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_ack_i,
  output logic [XLEN-1:0] fp_o,
  output logic [XLEN-1:0] sp_o,
  output logic [XLEN-1:0] pc_o,
  output logic            done_o
);
  cmd_e   cmd;
  state_e state;
  logic   take, step, finish;

  assign cmd = cmd_e'(cmd_i);

  frame_seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .ack_i    (mem_ack_i),
    .state_o  (state),
    .take_o   (take),
    .step_o   (step),
    .finish_o (finish)
  );

  frame_seq_path #(.XLEN(XLEN)) u_path (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .cmd_i    (cmd),
    .take_i   (take),
    .step_i   (step),
    .finish_i (finish),
    .pc_i     (pc_i),
    .target_i (target_i),
    .fp_i     (fp_i),
    .sp_i     (sp_i),
    .rdata_i  (mem_rdata_i),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o),
    .addr_o   (mem_addr_o),
    .wdata_o  (mem_wdata_o),
    .fp_o     (fp_o),
    .sp_o     (sp_o),
    .pc_o     (pc_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic            mem_ack_i,
  input logic [XLEN-1:0] fp_o,
  input logic [XLEN-1:0] sp_o,
  input logic [XLEN-1:0] pc_o,
  input logic            done_o
);
  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)));

  a_r11_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(fp_o) && $stable(sp_o) && $stable(pc_o)));

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  a_r8_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_req_o && mem_ack_i));
endmodule

bind frame_seq frame_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .fp_o        (fp_o),
  .sp_o        (sp_o),
  .pc_o        (pc_o),
  .done_o      (done_o)
);

// File: tb/frame_seq_test.sv
`timescale 1ns/1ps
module frame_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [31:0] pc_in = '0, tgt_in = '0, fp_in = '0, sp_in = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [31:0] fp_out, sp_out, pc_out;

  int unsigned n_chk = 0, n_fail = 0;
  int unsigned lat = 0, wcnt = 0;
  int unsigned n_acc = 0;
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  logic [31:0] log_data [64];

  always #4 clk = ~clk;

  frame_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .pc_i(pc_in), .target_i(tgt_in),
    .fp_i(fp_in), .sp_i(sp_in), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ack_i(mem_ack), .fp_o(fp_out), .sp_o(sp_out), .pc_o(pc_out),
    .done_o(done)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return 32'hC0DE_0000 ^ (a * 32'd7);
  endfunction

  // memory responder with programmable acknowledge latency
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_req) begin
      if (wcnt == lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_we ? 32'hDEAD_BEEF : word_at(mem_addr);
        log_addr[n_acc[5:0]] <= mem_addr;
        log_we[n_acc[5:0]]   <= mem_we;
        log_data[n_acc[5:0]] <= mem_wdata;
        n_acc <= n_acc + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  // inj: present a return command one cycle into the sequence
  task automatic run_call(input bit absf, input logic [31:0] sp, input logic [31:0] fp,
                          input logic [31:0] pc, input logic [31:0] tg, input bit inj);
    int unsigned b;
    logic [31:0] ra, base;
    b    = n_acc;
    ra   = pc + (absf ? 32'd6 : 32'd2);
    @(negedge clk);
    cmd = absf ? 2'b01 : 2'b10;
    sp_in = sp; fp_in = fp; pc_in = pc; tgt_in = tg;
    @(negedge clk);
    if (inj) begin
      cmd = 2'b11; sp_in = 32'h10; fp_in = 32'h20; pc_in = 32'h30; tgt_in = 32'h40;
      @(negedge clk);
    end
    cmd = 2'b00;
    wait_done();
    base = sp - 32'd12;
    chk("R4 fp after call", fp_out, base);
    chk("R4 sp after call", sp_out, base);
    chk("R4 pc after call", pc_out, tg);
    chk(inj ? "R9 access count with busy cmd" : "R2 call access count", n_acc - b, 2);
    chk("R2 first push addr", log_addr[b[5:0]], (sp - 32'd8) & ~32'd3);
    chk("R2 first push is write", {31'd0, log_we[b[5:0]]}, 1);
    chk("R5 return address word", log_data[b[5:0]], ra);
    chk("R3 second push addr", log_addr[b[5:0]+6'd1], (sp - 32'd12) & ~32'd3);
    chk("R3 second push is write", {31'd0, log_we[b[5:0]+6'd1]}, 1);
    chk("R3 old frame pointer word", log_data[b[5:0]+6'd1], fp);
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 0);
    repeat (3) @(negedge clk);
    chk("R10 pc held", pc_out, tg);
    chk(inj ? "R9 no extra access" : "R2 no access after call", n_acc - b, 2);
  endtask

  task automatic run_ret(input logic [31:0] fp, input logic [31:0] sp);
    int unsigned b;
    b = n_acc;
    @(negedge clk);
    cmd = 2'b11; fp_in = fp; sp_in = sp; pc_in = 32'h1234; tgt_in = 32'h5678;
    @(negedge clk);
    cmd = 2'b00;
    wait_done();
    chk("R7 fp after return", fp_out, word_at(fp));
    chk("R7 pc after return", pc_out, word_at(fp + 32'd4));
    chk("R7 sp after return", sp_out, fp + 32'd12);
    chk("R6 return access count", n_acc - b, 2);
    chk("R6 first read addr", log_addr[b[5:0]], fp);
    chk("R6 first is read", {31'd0, log_we[b[5:0]]}, 0);
    chk("R6 second read addr", log_addr[b[5:0]+6'd1], fp + 32'd4);
    chk("R6 second is read", {31'd0, log_we[b[5:0]+6'd1]}, 0);
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 0);
    chk("R10 sp held", sp_out, fp + 32'd12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fp reset", fp_out, 0);
    chk("R1 sp reset", sp_out, 0);
    chk("R1 pc reset", pc_out, 0);
    chk("R1 done reset", {31'd0, done}, 0);
    chk("R1 req reset", {31'd0, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", {31'd0, mem_req}, 0);

    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int i = 0; i < 6; i++) begin
        run_call(1'b1, 32'h80 + 32'(i * 20), 32'h44 + 32'(i * 4),
                 32'h1000 + 32'(i * 2), 32'h2000 + 32'(l * 16 + i), 1'b0);
        run_call(1'b0, 32'hF0 - 32'(i * 12), 32'h300 + 32'(i),
                 32'h4000 + 32'(i * 6), 32'h6000 + 32'(i), 1'b0);
        run_ret(32'h10 + 32'(i * 16), 32'h99);
      end
      run_call(1'b1, 32'hA0, 32'h55, 32'h700, 32'h900, 1'b1);
    end

    // R11: unaligned stack pointer still gives word-aligned accesses
    lat = 1;
    begin
      int unsigned b;
      b = n_acc;
      @(negedge clk);
      cmd = 2'b10; sp_in = 32'h8B; fp_in = 32'h11; pc_in = 32'h100; tgt_in = 32'h200;
      @(negedge clk);
      cmd = 2'b00;
      wait_done();
      chk("R11 aligned first push", log_addr[b[5:0]], 32'h80);
      chk("R11 aligned second push", log_addr[b[5:0]+6'd1], 32'h7C);
      chk("R11 sp after unaligned call", sp_out, 32'h7F);
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule